// File: doc/BRIEF.md
# OTG Connect Reset and Data Pulse Assist

This block takes two timed jobs of a USB On-The-Go port controller off software. With auto-reset enabled, a device connect on the port starts a bus reset in hardware at once. The reset lasts a fixed number of millisecond ticks. When it ends, the block sets a port-enable-change flag, and that flag holds the port-change interrupt high until software clears it. Software still sees the connect through a connect status bit, but it does not write any reset command.

Software can also write a start bit, and the block then drives a data-line pulse for a fixed number of ticks. The start bit and the pulse status bit both read 1 while the pulse runs and drop to 0 together when it ends, so software can poll them or just wait for bus power to appear. Both lengths come from parameters counted in `tick_ms` periods. The defaults are 10 ticks for the reset and 7 for the pulse, which keeps the pulse inside the 5 ms to 10 ms window. The block has no data stream: every pin is a plain control or status line.

Top module: `otg_assist_top`

## Requirements
- R1: A connect event (`conn_det` going 0 to 1) while `auto_en` is 1 and no bus reset is running raises `bus_reset_drv` on the next clock edge, well inside 1 ms. A connect event during a running reset is ignored and does not restart it.
- R2: `conn_sts` follows `conn_det` one clock later, whatever the value of `auto_en`. A connect while `auto_en` is 0 starts no reset.
- R3: The bus reset stays high for `RST_MS` ticks. It drops at the edge that samples the `RST_MS`-th tick after it started, and the same edge sets `en_chg`.
- R4: `port_irq` is high exactly while `en_chg` is 1. `en_chg` is cleared only by `sts_wr` with `sts_wdata`=1, a write of 0 has no effect, and a set in the same cycle wins over the clear.
- R5: `ctl_wr` with bit 1 of `ctl_wdata` set, while no pulse runs, raises `pulse_drv`, `pulse_go` and `pulse_sts` on the next edge.
- R6: The pulse ends on its own: all three pulse outputs fall at the edge that samples the `PULSE_MS`-th tick after the start.
- R7: A start write during a running pulse is ignored, and the pulse ends at its original tick.
- R8: Every `ctl_wr` loads `auto_en` from bit 0 of `ctl_wdata`. Clearing it while a reset runs does not shorten that reset.
- R9: While `rst_n` is low, every output is 0, including `auto_en`, `en_chg` and a pulse that was running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle strobe, once per millisecond |
| conn_det | input | 1 | Device connect level, synchronous to clk |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Bit 0 auto-reset enable, bit 1 pulse start |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 1 | 1 clears `en_chg` |
| conn_sts | output | 1 | Connect status |
| auto_en | output | 1 | Auto-reset enable readback |
| bus_reset_drv | output | 1 | Bus reset drive |
| en_chg | output | 1 | Port-enable-change flag |
| port_irq | output | 1 | Port-change interrupt |
| pulse_drv | output | 1 | Data-line pulse drive |
| pulse_go | output | 1 | Start bit readback, self-clearing |
| pulse_sts | output | 1 | Pulse-in-progress status |

## Verification
The assertions take for granted that `tick_ms` is a single-cycle strobe and that `conn_det` is already synchronous to `clk`. A tick that stays high for several cycles would count as several milliseconds, and an unsynchronised connect could give a spurious event. They also take for granted that both length parameters are at least 1. The stimulus changes every input at the falling edge and raises `tick_ms` for exactly one cycle per step. Writes, ticks and connect changes are placed on chosen cycles so that races such as a set colliding with a clear happen on purpose and not by accident.

// File: rtl/otg_assist_pkg.sv
package otg_assist_pkg;
  localparam int CTL_W         = 2;
  localparam int CTL_AUTO_BIT  = 0;
  localparam int CTL_PULSE_BIT = 1;
endpackage

// File: rtl/otg_ms_timer.sv
module otg_ms_timer #(
  parameter int LEN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt;
  logic          busy_q;

  assign busy = busy_q;
  assign done = busy_q && tick && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt    <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt    <= CW'(LEN);
    end else if (busy_q && tick) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) busy_q <= 1'b0;
    end
  end

  // R3 / R6: a running count stays within 1..LEN
  assert_cnt_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt != '0) && (cnt <= CW'(LEN)));

  // R6: each tick that does not finish the run removes exactly one step
  assert_tick_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tick && !done) |=> (busy_q && (cnt == $past(cnt) - CW'(1))));
endmodule

// File: rtl/otg_auto_reset.sv
module otg_auto_reset #(
  parameter int RST_MS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conn_det,
  input  logic tick,
  input  logic auto_en,
  input  logic chg_clr,
  output logic conn_sts,
  output logic reset_drv,
  output logic en_chg
);
  logic conn_q;
  logic conn_evt;
  logic rst_busy;
  logic rst_done;
  logic chg_q;

  assign conn_evt  = conn_det && !conn_q;
  assign conn_sts  = conn_q;
  assign reset_drv = rst_busy;
  assign en_chg    = chg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) conn_q <= 1'b0;
    else        conn_q <= conn_det;
  end

  otg_ms_timer #(.LEN(RST_MS)) rst_tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (conn_evt && auto_en),
    .tick  (tick),
    .busy  (rst_busy),
    .done  (rst_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        chg_q <= 1'b0;
    else if (rst_done) chg_q <= 1'b1;
    else if (chg_clr)  chg_q <= 1'b0;
  end

  // R1: a connect with auto-reset on starts the reset on the next edge
  assert_connect_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (conn_evt && auto_en && !rst_busy) |=> rst_busy);

  // R3: the end of a reset always leaves the enable-change flag set
  assert_end_sets_chg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_busy) |-> chg_q);

  // R4: a clear with no completing reset empties the flag
  assert_clear_works_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_clr && !rst_done) |=> !chg_q);

  // R4: without a clear the flag holds
  assert_chg_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_q && !chg_clr) |=> chg_q);

  // R8: nothing but the final tick ends a running reset
  assert_reset_not_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_busy && !rst_done) |=> rst_busy);
endmodule

// File: rtl/otg_data_pulse.sv
module otg_data_pulse #(
  parameter int PULSE_MS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_wr,
  input  logic tick,
  output logic active
);
  logic busy;
  logic done;

  otg_ms_timer #(.LEN(PULSE_MS)) pls_tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_wr),
    .tick  (tick),
    .busy  (busy),
    .done  (done)
  );

  assign active = busy;

  // R5: a start write while idle begins the pulse on the next edge
  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !busy) |=> busy);

  // R7: a start write during a pulse neither ends nor stretches it
  assert_restart_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_wr && !done) |=> busy);

  // R6: the pulse ends exactly when the last tick is taken
  assert_pulse_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |=> !busy);
endmodule

// File: rtl/otg_assist_top.sv
module otg_assist_top
  import otg_assist_pkg::*;
#(
  parameter int RST_MS   = 10,
  parameter int PULSE_MS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic             conn_det,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             sts_wr,
  input  logic             sts_wdata,
  output logic             conn_sts,
  output logic             auto_en,
  output logic             bus_reset_drv,
  output logic             en_chg,
  output logic             port_irq,
  output logic             pulse_drv,
  output logic             pulse_go,
  output logic             pulse_sts
);
  logic auto_q;
  logic pulse_active;

  always_ff @(posedge clk) begin
    if (!rst_n)      auto_q <= 1'b0;
    else if (ctl_wr) auto_q <= ctl_wdata[CTL_AUTO_BIT];
  end

  otg_auto_reset #(.RST_MS(RST_MS)) rst_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .conn_det  (conn_det),
    .tick      (tick_ms),
    .auto_en   (auto_q),
    .chg_clr   (sts_wr && sts_wdata),
    .conn_sts  (conn_sts),
    .reset_drv (bus_reset_drv),
    .en_chg    (en_chg)
  );

  otg_data_pulse #(.PULSE_MS(PULSE_MS)) pls_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_wr (ctl_wr && ctl_wdata[CTL_PULSE_BIT]),
    .tick     (tick_ms),
    .active   (pulse_active)
  );

  assign auto_en   = auto_q;
  assign port_irq  = en_chg;
  assign pulse_drv = pulse_active;
  assign pulse_go  = pulse_active;
  assign pulse_sts = pulse_active;

  // R8: the enable bit follows each control write
  assert_auto_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (auto_q == $past(ctl_wdata[CTL_AUTO_BIT])));
endmodule

// File: tb/otg_assist_top_tb_top.sv
`timescale 1ns/1ps
module otg_assist_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0, conn_det = 1'b0, ctl_wr = 1'b0, sts_wr = 1'b0, sts_wdata = 1'b0;
  logic [1:0] ctl_wdata = 2'b00;
  logic conn_sts, auto_en, bus_reset_drv, en_chg, port_irq, pulse_drv, pulse_go, pulse_sts;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  otg_assist_top #(.RST_MS(3), .PULSE_MS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .conn_det(conn_det),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .conn_sts(conn_sts), .auto_en(auto_en), .bus_reset_drv(bus_reset_drv),
    .en_chg(en_chg), .port_irq(port_irq), .pulse_drv(pulse_drv),
    .pulse_go(pulse_go), .pulse_sts(pulse_sts)
  );

  // {conn, cw, cd[1:0], sw, sd, tick | rst, pulse, chg, conn_sts, auto}
  localparam logic [11:0] VEC [18] = '{
    12'b0_0_00_0_0_0_0_0_0_0_0,
    12'b0_1_01_0_0_0_0_0_0_0_1,
    12'b1_0_00_0_0_0_1_0_0_1_1,
    12'b1_0_00_0_0_1_1_0_0_1_1,
    12'b1_1_00_0_0_0_1_0_0_1_0,
    12'b1_0_00_0_0_1_1_0_0_1_0,
    12'b1_0_00_0_0_0_1_0_0_1_0,
    12'b1_0_00_0_0_1_0_0_1_1_0,
    12'b1_0_00_1_0_0_0_0_1_1_0,
    12'b1_0_00_1_1_0_0_0_0_1_0,
    12'b1_1_10_0_0_0_0_1_0_1_0,
    12'b1_0_00_0_0_1_0_1_0_1_0,
    12'b1_1_10_0_0_0_0_1_0_1_0,
    12'b1_0_00_0_0_1_0_1_0_1_0,
    12'b1_0_00_0_0_1_0_1_0_1_0,
    12'b1_0_00_0_0_1_0_0_0_1_0,
    12'b0_0_00_0_0_0_0_0_0_0_0,
    12'b1_0_00_0_0_0_0_0_0_1_0
  };

  function automatic string row_tag(int i);
    case (i)
      1, 4:          return "R8";
      2:             return "R1";
      3, 5, 6, 7:    return "R3";
      8, 9:          return "R4";
      10, 11:        return "R5";
      12, 13, 14:    return "R7";
      15:            return "R6";
      16, 17:        return "R2";
      default:       return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic cw, input logic [1:0] cd,
                     input logic sw, input logic sd, input logic tk);
    conn_det = c; ctl_wr = cw; ctl_wdata = cd; sts_wr = sw; sts_wdata = sd; tick_ms = tk;
    @(negedge clk);
  endtask

  task automatic chk_all(input string tag, input logic r, input logic p,
                         input logic g, input logic cs, input logic a);
    chk(tag, "bus_reset_drv", bus_reset_drv, r);
    chk(tag, "pulse_drv", pulse_drv, p);
    chk(tag, "pulse_go", pulse_go, p);
    chk(tag, "pulse_sts", pulse_sts, p);
    chk(tag, "en_chg", en_chg, g);
    chk(tag, "port_irq", port_irq, g);
    chk(tag, "conn_sts", conn_sts, cs);
    chk(tag, "auto_en", auto_en, a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R9", 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    // table walk
    for (int i = 0; i < 18; i++) begin
      cyc(VEC[i][11], VEC[i][10], VEC[i][9:8], VEC[i][7], VEC[i][6], VEC[i][5]);
      chk_all(row_tag(i), VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end
    // R1 R5: connect and pulse start together, both run
    cyc(0, 1, 2'b01, 0, 0, 0);
    cyc(1, 1, 2'b11, 0, 0, 0);
    chk_all("R1", 1, 1, 0, 1, 1);
    cyc(1, 0, 2'b00, 0, 0, 1);
    cyc(1, 0, 2'b00, 0, 0, 1);
    chk_all("R3", 1, 1, 0, 1, 1);
    cyc(1, 0, 2'b00, 0, 0, 1);
    chk_all("R3", 0, 1, 1, 1, 1);
    cyc(1, 0, 2'b00, 0, 0, 1);
    chk_all("R6", 0, 0, 1, 1, 1);
    // R4 clear, then reconnect inside a reset (R1), set beats clear (R4)
    cyc(1, 0, 2'b00, 1, 1, 0);
    chk("R4", "en_chg cleared", en_chg, 1'b0);
    cyc(0, 0, 2'b00, 0, 0, 0);
    cyc(1, 0, 2'b00, 0, 0, 0);
    chk("R1", "reset on reconnect", bus_reset_drv, 1'b1);
    cyc(1, 0, 2'b00, 0, 0, 1);
    cyc(0, 0, 2'b00, 0, 0, 0);
    cyc(1, 0, 2'b00, 0, 0, 0);
    cyc(1, 0, 2'b00, 0, 0, 1);
    chk("R1", "reconnect does not restart", bus_reset_drv, 1'b1);
    cyc(1, 0, 2'b00, 1, 1, 1);
    chk("R1", "reset ends on original tick", bus_reset_drv, 1'b0);
    chk("R4", "set wins over clear", en_chg, 1'b1);
    chk("R4", "irq with set", port_irq, 1'b1);
    // R9: reset in the middle of a pulse
    cyc(1, 1, 2'b11, 0, 0, 0);
    chk("R5", "pulse before reset", pulse_sts, 1'b1);
    rst_n = 1'b0;
    cyc(0, 0, 2'b00, 0, 0, 0);
    chk_all("R9", 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    cyc(0, 0, 2'b00, 0, 0, 0);
    chk_all("R9", 0, 0, 0, 0, 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule